// File: doc/BRIEF.md
# Slow-Oscillator Detecting Reference Clock Selector

This block picks the reference clock for a real-time counter. At power-on it always drives the reference from the main oscillator. Once the reset pin has been released after power-on, it watches the low-frequency oscillator input for a bounded number of main-clock cycles. If enough rising edges arrive in that window, it commits to the slow clock and hands the reference over through a glitch-free multiplexer. If too few arrive, it keeps the main clock until the next power-on.

The decision is made once per power-on. A warm reset on the reset pin alone neither repeats detection nor undoes the choice. Software can move the reference back to the main clock with a force bit. That return is final until the next power-on. A power-down request halts the reference only when the counter is not running. While the counter runs, the reference keeps toggling.

A status output reports which source drives the reference at the moment.

Top module: `rtc_refsel`

## Requirements
- R1: While por_n is low, ref_is_slow is 0 and ref_clk follows clk_main.
- R2: Slow-clock edges that arrive while rst_pin_n is still low after power-on are not counted toward detection.
- R3: After rst_pin_n is released, if at least EDGES (default 3) rising edges of clk_slow arrive within WINDOW main-clock cycles, the reference moves to clk_slow and ref_is_slow becomes 1.
- R4: If fewer than EDGES rising edges arrive within the window, the reference stays on clk_main even when clk_slow starts running later, until the next power-on.
- R5: A pulse on force_main while the slow clock is selected returns the reference to clk_main. It stays there after force_main falls.
- R6: A new power-on (por_n low) returns the reference to clk_main and re-arms detection, so a running slow clock is selected again afterwards.
- R7: Pulsing rst_pin_n low after the selection is made changes neither the selection nor ref_is_slow.
- R8: With pwrdn_req high and rtc_run high, ref_clk keeps toggling at the selected rate. With pwrdn_req high and rtc_run low, ref_clk stops. It resumes when pwrdn_req falls.
- R9: The two source enables are never active together, and ref_clk toggles at the rate of the source that ref_is_slow reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main oscillator clock; all control logic runs in this domain |
| clk_slow | input | 1 | Low-frequency oscillator clock, possibly absent |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Reset pin, active low; its release starts detection |
| force_main | input | 1 | Software request to return the reference to clk_main |
| rtc_run | input | 1 | High while the real-time counter is enabled |
| pwrdn_req | input | 1 | Power-down request |
| ref_clk | output | 1 | Selected reference clock |
| ref_is_slow | output | 1 | 1 when clk_slow is driving ref_clk |

## Verification
The main function is exercised with a sweep over the number of slow-clock pulses inside the detection window, from zero up to five. The expected selection is computed as "count at least EDGES", so the sweep marks the exact threshold: two pulses must not switch, three must. Each run also sends pulses while the reset pin is still low, which tells a detector that starts too early from a correct one. After each run the slow clock is left running freely, to show that a failed detection stays final. Edge counts of ref_clk over a fixed interval tell the main rate, the slow rate and a stopped clock apart, covering the warm-reset, software-return, power-down and re-power cases.

// File: rtl/rtc_refsel_pkg.sv
package rtc_refsel_pkg;

    // Detection sequencer states; encoding is shared with the checker.
    typedef enum logic [1:0] {
        DS_ARM  = 2'd0,   // waiting for the reset pin to be released
        DS_SCAN = 2'd1,   // counting slow edges inside the window
        DS_SLOW = 2'd2,   // slow clock committed
        DS_MAIN = 2'd3    // main clock final until next power-on
    } det_state_e;

endpackage

// File: rtl/rtc_refsel_detect.sv
module rtc_refsel_detect
    import rtc_refsel_pkg::*;
#(
    parameter int unsigned WINDOW = 2048,
    parameter int unsigned EDGES  = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_n,
    input  logic       slow_raw,
    input  logic       force_main,
    output logic       want_slow,
    output det_state_e state
);

    localparam int unsigned WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int unsigned EW = $clog2(EDGES + 1);
    localparam logic [WW-1:0] WIN_LAST  = WW'(WINDOW - 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

    typedef struct packed {
        det_state_e    st;
        logic [1:0]    pin_sh;   // reset pin synchroniser
        logic [2:0]    slw_sh;   // two sync stages plus edge history
        logic [WW-1:0] win;
        logic [EW-1:0] edg;
    } det_t;

    det_t det_d, det_q;
    logic slow_rise;

    always_comb begin
        det_d        = det_q;
        det_d.pin_sh = {det_q.pin_sh[0], pin_n};
        det_d.slw_sh = {det_q.slw_sh[1:0], slow_raw};
        slow_rise    = det_q.slw_sh[1] & ~det_q.slw_sh[2];

        unique case (det_q.st)
            DS_ARM: begin
                if (det_q.pin_sh[1]) begin
                    det_d.st  = DS_SCAN;
                    det_d.win = '0;
                    det_d.edg = '0;
                end
            end
            DS_SCAN: begin
                if (slow_rise && det_q.edg == EDGE_LAST) begin
                    det_d.st = DS_SLOW;
                end else if (det_q.win == WIN_LAST) begin
                    det_d.st = DS_MAIN;
                end else begin
                    det_d.win = det_q.win + 1'b1;
                    if (slow_rise) det_d.edg = det_q.edg + 1'b1;
                end
            end
            DS_SLOW: begin
                if (force_main) det_d.st = DS_MAIN;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign want_slow = (det_q.st == DS_SLOW);
    assign state     = det_q.st;

endmodule

// File: rtl/rtc_refsel_gmux.sv
module rtc_refsel_gmux #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk_main,
    input  logic            clk_slow,
    input  logic            rst_n,
    input  logic            sel_slow,
    input  logic            hold,
    output logic [NSRC-1:0] en,
    output logic            clk_out
);

    logic [NSRC-1:0] clk_src;
    logic [NSRC-1:0] req;

    assign clk_src = {clk_slow, clk_main};
    assign req     = {sel_slow & ~hold, ~sel_slow & ~hold};

    for (genvar i = 0; i < NSRC; i++) begin : g_lane
        localparam logic INIT = (i == 0);
        localparam int   OTH  = NSRC - 1 - i;
        logic s_q, e_q;

        // Stage 1: take the request once the other lane has let go.
        always_ff @(posedge clk_src[i] or negedge rst_n) begin
            if (!rst_n) s_q <= INIT;
            else        s_q <= req[i] & ~en[OTH];
        end

        // Stage 2: change the enable only while this source is low.
        always_ff @(negedge clk_src[i] or negedge rst_n) begin
            if (!rst_n) e_q <= INIT;
            else        e_q <= s_q;
        end

        assign en[i] = e_q;
    end

    assign clk_out = |(clk_src & en);

endmodule

// File: rtl/rtc_refsel_chk.sv
module rtc_refsel_chk
    import rtc_refsel_pkg::*;
(
    input logic       clk_main,
    input logic       por_n,
    input logic       force_main,
    input logic       en_main,
    input logic       en_slow,
    input det_state_e det_state
);

    // R9: never two sources on the output at once
    p_one_src_r9: assert property (@(posedge clk_main) disable iff (!por_n)
        !(en_main && en_slow));

    // R4: a failed detection is final until power-on
    p_main_final_r4: assert property (@(posedge clk_main) disable iff (!por_n)
        (det_state == DS_MAIN) |=> (det_state == DS_MAIN));

    // R5: software request leaves the slow selection
    p_force_back_r5: assert property (@(posedge clk_main) disable iff (!por_n)
        (det_state == DS_SLOW && force_main) |=> (det_state == DS_MAIN));

    // R2: no decision before scanning has started
    p_arm_wait_r2: assert property (@(posedge clk_main) disable iff (!por_n)
        (det_state == DS_ARM) |=> (det_state == DS_ARM || det_state == DS_SCAN));

    // R7: the slow selection holds without a software request
    p_slow_hold_r7: assert property (@(posedge clk_main) disable iff (!por_n)
        (det_state == DS_SLOW && !force_main) |=> (det_state == DS_SLOW));

endmodule

bind rtc_refsel rtc_refsel_chk u_chk (
    .clk_main  (clk_main),
    .por_n     (por_n),
    .force_main(force_main),
    .en_main   (src_en[0]),
    .en_slow   (src_en[1]),
    .det_state (det_state)
);

// File: rtl/rtc_refsel.sv
module rtc_refsel
    import rtc_refsel_pkg::*;
#(
    parameter int unsigned WINDOW = 2048,
    parameter int unsigned EDGES  = 3
) (
    input  logic clk_main,
    input  logic clk_slow,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic force_main,
    input  logic rtc_run,
    input  logic pwrdn_req,
    output logic ref_clk,
    output logic ref_is_slow
);

    localparam int unsigned NSRC = 2;

    logic            want_slow;
    logic            hold;
    logic [NSRC-1:0] src_en;
    det_state_e      det_state;

    assign hold = pwrdn_req & ~rtc_run;

    rtc_refsel_detect #(
        .WINDOW(WINDOW),
        .EDGES (EDGES)
    ) u_detect (
        .clk       (clk_main),
        .por_n     (por_n),
        .pin_n     (rst_pin_n),
        .slow_raw  (clk_slow),
        .force_main(force_main),
        .want_slow (want_slow),
        .state     (det_state)
    );

    rtc_refsel_gmux #(
        .NSRC(NSRC)
    ) u_gmux (
        .clk_main(clk_main),
        .clk_slow(clk_slow),
        .rst_n   (por_n),
        .sel_slow(want_slow),
        .hold    (hold),
        .en      (src_en),
        .clk_out (ref_clk)
    );

    assign ref_is_slow = src_en[1];

endmodule

// File: tb/rtc_refsel_tb.sv
module rtc_refsel_tb;

    localparam int WINDOW = 64;
    localparam int EDGES  = 3;
    localparam int N_MAIN = 50;   // ref edges in 400 at period 8
    localparam int N_SLOW = 10;   // ref edges in 400 at period 40

    logic clk_main = 1'b0;
    logic clk_slow = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin_n = 1'b0;
    logic force_main = 1'b0;
    logic rtc_run = 1'b1;
    logic pwrdn_req = 1'b0;
    logic ref_clk, ref_is_slow;

    int  n_total = 0;
    int  n_fail  = 0;
    int  pulses_left = 0;
    bit  free_run = 1'b0;
    bit  counting = 1'b0;
    int  edge_cnt = 0;
    bit  done = 1'b0;

    rtc_refsel #(.WINDOW(WINDOW), .EDGES(EDGES)) u_dut (
        .clk_main(clk_main), .clk_slow(clk_slow), .por_n(por_n),
        .rst_pin_n(rst_pin_n), .force_main(force_main), .rtc_run(rtc_run),
        .pwrdn_req(pwrdn_req), .ref_clk(ref_clk), .ref_is_slow(ref_is_slow)
    );

    always #4 clk_main = ~clk_main;

    initial begin
        forever begin
            if (free_run || pulses_left > 0) begin
                clk_slow = 1'b1; #20;
                clk_slow = 1'b0; #20;
                if (pulses_left > 0) pulses_left--;
            end else begin
                #4;
            end
        end
    end

    always @(posedge ref_clk) if (counting) edge_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rate(input string req, input int exp);
        int n;
        edge_cnt = 0; counting = 1'b1; #400; counting = 1'b0;
        n = edge_cnt;
        chk((n >= exp - 1) && (n <= exp + 1), req, n, exp);
    endtask

    task automatic trial(input int n);
        bit exp_slow;
        por_n = 1'b0; rst_pin_n = 1'b0; free_run = 1'b0; pulses_left = 0;
        force_main = 1'b0; pwrdn_req = 1'b0; rtc_run = 1'b1;
        #80;
        chk(ref_is_slow == 1'b0, "R1", ref_is_slow, 0);
        rate("R1", N_MAIN);
        por_n = 1'b1; #40;
        pulses_left = 5;                 // pulses while the pin is held
        wait (pulses_left == 0); #60;
        rst_pin_n = 1'b1; #40;
        pulses_left = n;                 // pulses inside the window
        #700; free_run = 1'b1; #300;
        exp_slow = (n >= EDGES);
        if (n == 0) chk(ref_is_slow == 1'b0, "R2", ref_is_slow, 0);
        chk(ref_is_slow == exp_slow, exp_slow ? "R3" : "R4", ref_is_slow, exp_slow);
        rate("R9", exp_slow ? N_SLOW : N_MAIN);
    endtask

    initial begin
        #200000;
        n_total++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        for (int n = 0; n <= 5; n++) trial(n);

        // R7: warm reset keeps the slow selection
        rst_pin_n = 1'b0; #100; rst_pin_n = 1'b1; #300;
        chk(ref_is_slow == 1'b1, "R7", ref_is_slow, 1);
        rate("R7", N_SLOW);

        // R8: power-down with the counter running, then stopped
        pwrdn_req = 1'b1; rtc_run = 1'b1; #200;
        rate("R8", N_SLOW);
        rtc_run = 1'b0; #200;
        rate("R8", 0);
        pwrdn_req = 1'b0; rtc_run = 1'b1; #300;
        chk(ref_is_slow == 1'b1, "R8", ref_is_slow, 1);
        rate("R8", N_SLOW);

        // R5: software returns the reference to the main clock
        @(negedge clk_main); force_main = 1'b1;
        @(negedge clk_main); @(negedge clk_main); force_main = 1'b0;
        #300;
        chk(ref_is_slow == 1'b0, "R5", ref_is_slow, 0);
        rate("R5", N_MAIN);
        #500;
        chk(ref_is_slow == 1'b0, "R5", ref_is_slow, 0);

        // R6: new power-on re-arms detection with the slow clock running
        por_n = 1'b0; rst_pin_n = 1'b0; #80;
        chk(ref_is_slow == 1'b0, "R6", ref_is_slow, 0);
        rate("R6", N_MAIN);
        por_n = 1'b1; #40; rst_pin_n = 1'b1; #800;
        chk(ref_is_slow == 1'b1, "R6", ref_is_slow, 1);
        rate("R6", N_SLOW);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule